// File: doc/BRIEF.md
# Multi-Pipe Interrupt Aggregator

This block merges interrupt events from a set of transfer pipes and from the shared controller logic into one level-sensitive interrupt line for a single execution environment. Each pipe keeps its own sticky status bits, an enable register and a write-one-to-clear register. The controller-wide events have their own status, enable and clear registers.

A summary source register has one bit for each pipe and a top bit for the controller-wide events. A source bit is set when its status has at least one enabled bit pending. A mask register with the same layout decides which source bits reach the interrupt line, and that line is registered. Software reads the source register to find which pipes need service. It reads the status of each of those pipes and writes the value back to the matching clear register.

The register port uses word addresses (`reg_addr_i`) and combinational reads. The word map is: 0 source (read-only), 1 mask, 2 global status (read-only), 3 global enable, 4 global clear. Pipe p starts at word 16+4p, with status at +0 (read-only), enable at +1 and clear at +2. Clear registers and unmapped words read as zero.

Top module: `intr_aggregator`

## Requirements
- R1: Source register (word 0) bit p reads 1 exactly when pipe p has a status bit that is set and also enabled (pipe enable at word 16+4p+1).
- R2: Source bit 31 reads 1 exactly when the global status ANDed with the global enable (word 3) is nonzero. All source bits other than the pipe bits and bit 31 read 0.
- R3: The mask (word 1) uses the source layout. `irq_o` is 1 one clock after any source bit is set together with its mask bit, and 0 one clock after none is.
- R4: Global status (word 2) bit positions are: timer event at bit 4, descriptor-empty at bit 3, error at bit 2 and bus response error at bit 1 (`glb_evt_i` bits 4..1). Bit 0 and bits 31..5 always read 0.
- R5: Global enable (word 3) and global clear (word 4) use the bit positions of R4. Writing a 1 to a global clear bit clears that status bit.
- R6: A pipe or global status bit latches on its event pulse whether it is enabled or not. Enables only gate the contribution to the source register. A pipe enable stores only its low PIPE_BITS bits.
- R7: Writing the pipe clear register (word 16+4p+2) clears each status bit written as 1 and leaves the status bits written as 0 unchanged.
- R8: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: After reset every status, enable and mask bit is 0 and `irq_o` is 0.
- R10: Writes to the source register and to the status registers (words 0, 2, 16+4p) have no effect. Clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_evt_i | input | NUM_PIPES*PIPE_BITS | Per-pipe event pulses; pipe p occupies bits p*PIPE_BITS upward |
| glb_evt_i | input | 5 | Global event pulses, positions per R4 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt line |

## Verification
On every cycle, assertions check the following. An event always leaves its status bit set, even when a clear hits the same bit. A clear with no event removes the bit. No status bit sets without an event. The interrupt line follows the masked source one clock later in both directions. The bench scenarios cover what needs the register map. This includes the exact source bit positions, the global bit layout, and reserved bits reading zero. It also covers writes to read-only words being ignored and the one-cycle lag of `irq_o` seen at the port.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int REG_W        = 32;
  localparam int GLB_W        = 5;
  localparam logic [GLB_W-1:0] GLB_VALID = 5'b11110;
  localparam int SRC_GLB_BIT  = 31;
  localparam int A_SRC        = 0;
  localparam int A_MASK       = 1;
  localparam int A_GSTAT      = 2;
  localparam int A_GEN        = 3;
  localparam int A_GCLR       = 4;
  localparam int PIPE_BASE    = 16;
  localparam int PIPE_STRIDE  = 4;
  localparam int OFS_STAT     = 0;
  localparam int OFS_EN       = 1;
  localparam int OFS_CLR      = 2;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int              WIDTH = 6,
  parameter logic [WIDTH-1:0] VALID = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] stat_o,
  output logic [WIDTH-1:0] en_o,
  output logic             pend_o
);
  logic [WIDTH-1:0] stat_q, en_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i & VALID;
      // event ORed after clear: event wins
      stat_q <= ((stat_q & ~clr_vec) | evt_i) & VALID;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((stat_o & $past(wdata_i & ~evt_i)) == '0));

  p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import intr_agg_pkg::*;
#(
  parameter int NUM_PIPES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PIPES-1:0] pipe_pend_i,
  input  logic                 glb_pend_i,
  input  logic                 mask_we_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     src_o,
  output logic [REG_W-1:0]     mask_o,
  output logic                 irq_o
);
  localparam logic [REG_W-1:0] SRC_VALID =
    (REG_W'(1) << SRC_GLB_BIT) | ((REG_W'(1) << NUM_PIPES) - REG_W'(1));

  logic [REG_W-1:0] mask_q;
  logic             irq_q;

  always_comb begin
    src_o = '0;
    src_o[NUM_PIPES-1:0] = pipe_pend_i;
    src_o[SRC_GLB_BIT]   = glb_pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & SRC_VALID;
      irq_q <= |(src_o & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_irq_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(src_o & mask_o)) |=> irq_o);

  p_irq_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(src_o & mask_o)) |=> !irq_o);
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_agg_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int PIPE_BITS = 6,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PIPES*PIPE_BITS-1:0] pipe_evt_i,
  input  logic [GLB_W-1:0]               glb_evt_i,
  input  logic                           reg_we_i,
  input  logic [ADDR_W-1:0]              reg_addr_i,
  input  logic [REG_W-1:0]               reg_wdata_i,
  output logic [REG_W-1:0]               reg_rdata_o,
  output logic                           irq_o
);
  logic [PIPE_BITS-1:0] pipe_stat [NUM_PIPES];
  logic [PIPE_BITS-1:0] pipe_en   [NUM_PIPES];
  logic [NUM_PIPES-1:0] pipe_pend;
  logic [GLB_W-1:0]     glb_stat, glb_en;
  logic                 glb_pend;
  logic [REG_W-1:0]     src, mask;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    localparam int BASE = PIPE_BASE + PIPE_STRIDE * p;
    irq_stat_bank #(.WIDTH(PIPE_BITS), .VALID({PIPE_BITS{1'b1}})) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (pipe_evt_i[p*PIPE_BITS +: PIPE_BITS]),
      .en_we_i  (reg_we_i && (reg_addr_i == ADDR_W'(BASE + OFS_EN))),
      .clr_we_i (reg_we_i && (reg_addr_i == ADDR_W'(BASE + OFS_CLR))),
      .wdata_i  (reg_wdata_i[PIPE_BITS-1:0]),
      .stat_o   (pipe_stat[p]),
      .en_o     (pipe_en[p]),
      .pend_o   (pipe_pend[p])
    );
  end

  irq_stat_bank #(.WIDTH(GLB_W), .VALID(GLB_VALID)) u_glb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (glb_evt_i),
    .en_we_i  (reg_we_i && (reg_addr_i == ADDR_W'(A_GEN))),
    .clr_we_i (reg_we_i && (reg_addr_i == ADDR_W'(A_GCLR))),
    .wdata_i  (reg_wdata_i[GLB_W-1:0]),
    .stat_o   (glb_stat),
    .en_o     (glb_en),
    .pend_o   (glb_pend)
  );

  irq_summary #(.NUM_PIPES(NUM_PIPES)) u_sum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_pend_i (pipe_pend),
    .glb_pend_i  (glb_pend),
    .mask_we_i   (reg_we_i && (reg_addr_i == ADDR_W'(A_MASK))),
    .wdata_i     (reg_wdata_i),
    .src_o       (src),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_SRC):   reg_rdata_o = src;
      ADDR_W'(A_MASK):  reg_rdata_o = mask;
      ADDR_W'(A_GSTAT): reg_rdata_o = REG_W'(glb_stat);
      ADDR_W'(A_GEN):   reg_rdata_o = REG_W'(glb_en);
      default: begin
        for (int p = 0; p < NUM_PIPES; p++) begin
          if (reg_addr_i == ADDR_W'(PIPE_BASE + PIPE_STRIDE * p + OFS_STAT))
            reg_rdata_o = REG_W'(pipe_stat[p]);
          if (reg_addr_i == ADDR_W'(PIPE_BASE + PIPE_STRIDE * p + OFS_EN))
            reg_rdata_o = REG_W'(pipe_en[p]);
        end
      end
    endcase
  end

  p_src_glb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_evt_i[2] && glb_en[2]) |=> src[SRC_GLB_BIT]);
endmodule

// File: tb/tb_intr_aggregator.sv
module tb_intr_aggregator;
  localparam int NP = 4;
  localparam int PB = 6;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP*PB-1:0] pipe_evt = '0;
  logic [4:0]     glb_evt = '0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_aggregator #(.NUM_PIPES(NP), .PIPE_BITS(PB), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pipe_evt_i(pipe_evt), .glb_evt_i(glb_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  function automatic int pa(int p, int ofs);
    return 16 + 4 * p + ofs;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    addr = AW'(a);
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse_pipe(int p, logic [PB-1:0] b);
    @(negedge clk);
    pipe_evt[p*PB +: PB] = b;
    @(negedge clk);
    pipe_evt = '0;
  endtask

  task automatic t_reset;
    rd_chk("R9 src", 0, 32'h0);
    rd_chk("R9 mask", 1, 32'h0);
    rd_chk("R9 pipe0 stat", pa(0, 0), 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latch_disabled;
    pulse_pipe(1, 6'h05);
    rd_chk("R6 stat latched while disabled", pa(1, 0), 32'h05);
    rd_chk("R6 src stays 0", 0, 32'h0);
    wr(pa(1, 1), 32'hFF);
    rd_chk("R6 enable width", pa(1, 1), 32'h3F);
    wr(pa(1, 1), 32'h01);
    rd_chk("R1 src pipe1", 0, 32'h2);
  endtask

  task automatic t_mask_irq;
    check("R3 irq masked", {31'b0, irq}, 32'h0);
    wr(1, 32'h2);
    check("R3 irq one clock late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R3 irq set", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c;
    wr(pa(1, 2), 32'h01);
    rd_chk("R7 stat after clear", pa(1, 0), 32'h04);
    rd_chk("R1 src after clear", 0, 32'h0);
    check("R3 irq lag on fall", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R3 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_global;
    @(negedge clk);
    glb_evt = 5'b11111;
    @(negedge clk);
    glb_evt = '0;
    rd_chk("R4 gstat layout", 2, 32'h1E);
    rd_chk("R2 src without enable", 0, 32'h0);
    wr(3, 32'h04);
    rd_chk("R2 src bit31", 0, 32'h8000_0000);
    wr(1, 32'h8000_0002);
    @(negedge clk);
    check("R3 irq from global", {31'b0, irq}, 32'h1);
    wr(4, 32'h05);
    rd_chk("R5 gclr", 2, 32'h1A);
    rd_chk("R2 src after gclr", 0, 32'h0);
    @(negedge clk);
    check("R3 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collision;
    pulse_pipe(2, 6'h01);
    @(negedge clk);
    pipe_evt[2*PB +: PB] = 6'h08;
    we = 1'b1; addr = AW'(pa(2, 2)); wdata = 32'h09;
    @(negedge clk);
    we = 1'b0; pipe_evt = '0;
    rd_chk("R8 event wins", pa(2, 0), 32'h08);
  endtask

  task automatic t_readonly;
    wr(0, 32'hFFFF_FFFF);
    rd_chk("R10 src write ignored", 0, 32'h0);
    rd_chk("R10 mask untouched", 1, 32'h8000_0002);
    wr(2, 32'hFF);
    rd_chk("R10 gstat write ignored", 2, 32'h1A);
    wr(pa(2, 0), 32'h0);
    rd_chk("R10 pipe stat write ignored", pa(2, 0), 32'h08);
    rd_chk("R10 gclr reads 0", 4, 32'h0);
    rd_chk("R10 pipe clr reads 0", pa(2, 2), 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_disabled();
    t_mask_irq();
    t_w1c();
    t_global();
    t_collision();
    t_readonly();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule